// File: doc/BRIEF.md
# Bi-phase Mark Digital-Audio Subframe Encoder

This block turns a stream of stereo 16-bit audio samples into a consumer digital-audio serial line. Each sample becomes a 32-slot subframe. The subframe holds a four-slot synchronisation preamble, zeroed auxiliary and padding slots, the two's-complement sample, a validity bit, a user-data bit, a channel-status bit and an even-parity bit. Left and right subframes alternate. Every 384 subframes form a block. The first left subframe of a block carries preamble B, other left subframes carry M, and right subframes carry W. The line is bi-phase mark coded, so each slot is sent as two half-cells.

A strobe input sets the line pace: each strobe advances the line by one half-cell, so the strobe must run at twice the bit rate. The block samples its data inputs itself as each subframe begins, and it reports this with a one-cycle pulse. The feeding logic can then present the next values. The left and right samples and their error flags are taken together at the start of each left subframe. The user bit is taken at every subframe start. The four control bits and the clock-accuracy code that fill the channel-status word are taken once per block. The block builds the 192-bit channel-status word itself; it describes a disc-audio source. A mode input either holds the line low with all framing at rest, or runs the encoder.

Top module: `bmc_subframe_tx`

## Requirements
- R1: After reset, and in any cycle that follows a clock edge at which `line_on` was 0, `line_out` is 0. `sub_start` and `blk_first` are also 0 then.
- R2: Subframes alternate left and right. Subframe 0 of each 384-subframe block carries preamble B. Other even-numbered subframes carry M, and odd-numbered subframes carry W. Written as the eight half-cells of the preamble, first half-cell first, with the line low before it: B is 11101000, M is 11100010 and W is 11100100. If the line was high before the preamble, all eight half-cells are inverted.
- R3: Each of slots 4 to 31 starts with a line transition. A slot holding 1 has a second transition at mid-slot; a slot holding 0 has none. The preamble polarity follows the line level at the end of the previous subframe. That level is low for the first subframe after `line_on` rises.
- R4: Slots 4 to 11 are 0. Slot 12 holds the LSB of the sample and slot 27 holds its MSB. Even subframes carry `smp_left` and odd subframes carry `smp_right`.
- R5: Slot 28 is 1 when the error flag of the carried sample (`err_left` or `err_right`) was 1, and 0 otherwise.
- R6: Slot 29 carries the value of `user_bit` sampled when that subframe began.
- R7: Slot 30 of subframes 2k and 2k+1 carries channel-status bit k, for k from 0 to 191. Bits 0 to 3 equal `q_ctrl[0]` to `q_ctrl[3]`. Bit 8 is 1. Bit 28 equals `clk_acc[1]` and bit 29 equals `clk_acc[0]`; the codes are 10 for class 1, 00 for class 2 and 01 for class 3. Every other bit is 0.
- R8: Slot 31 makes the number of ones in slots 4 to 31 even.
- R9: `q_ctrl` and `clk_acc` are sampled only at the start of subframe 0 of a block. A change during a block first shows in the next block.
- R10: With `line_on` at 1, a clock edge at which `cell_en` is 0 leaves `line_out` unchanged.
- R11: `sub_start` is 1 for one cycle right after the strobe that starts a subframe. That strobe is also the edge at which the data inputs are sampled. `blk_first` is 1 together with `sub_start` only for subframe 0 of a block.
- R12: When `line_on` rises, encoding restarts at subframe 0 of a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_on | input | 1 | 1 runs the encoder; 0 holds the line low and rewinds framing |
| cell_en | input | 1 | Half-cell strobe at twice the bit rate |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| err_left | input | 1 | Left sample could not be corrected |
| err_right | input | 1 | Right sample could not be corrected |
| user_bit | input | 1 | Next bit of the subcode user stream |
| q_ctrl | input | 4 | Checked control bits copied into channel status bits 0 to 3 |
| clk_acc | input | 2 | Clock-accuracy code for channel status bits 28 and 29 |
| line_out | output | 1 | Bi-phase mark coded serial line |
| sub_start | output | 1 | Pulse: a subframe began and its inputs were sampled |
| blk_first | output | 1 | Pulse with sub_start on the first subframe of a block |

## Verification
A wrong half-cell counter shows within one subframe: a slot loses its leading transition, or the preamble lands in the wrong place. Either way the decoded word is garbled within 64 strobes. A wrong subframe counter shows as a preamble letter in the wrong place. This shows at once if left and right are swapped. If the block length is wrong, it shows at the first block boundary, 384 subframes in. It can also show as channel-status bits that shift against their pair index. A stale capture register shows as a sample, flag or channel-status field that lags by one pair or one block. A wrong polarity register inverts a preamble at the next subframe.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int SLOTS      = 32;
    localparam int HALVES     = 2 * SLOTS;
    localparam int HCNT_W     = $clog2(HALVES);
    localparam int PRE_HALVES = 8;
    localparam int CS_BITS    = 192;

    typedef enum logic [1:0] {
        PRE_BLK  = 2'd0,
        PRE_LEFT = 2'd1,
        PRE_RGT  = 2'd2
    } pre_kind_t;

    typedef struct packed {
        logic [3:0] ctrl;
        logic [1:0] acc;
    } cs_cfg_t;

    // Preamble half-cells for a line that was low before it, first half-cell in bit 7.
    function automatic logic [7:0] pre_pattern(pre_kind_t kind);
        case (kind)
            PRE_BLK:  return 8'b1110_1000;
            PRE_LEFT: return 8'b1110_0010;
            default:  return 8'b1110_0100;
        endcase
    endfunction

    // Channel-status bit for a disc-audio source.
    function automatic logic cs_value(logic [15:0] idx, cs_cfg_t cfg);
        if (idx < 16'd4)        return cfg.ctrl[idx[1:0]];
        else if (idx == 16'd8)  return 1'b1;
        else if (idx == 16'd28) return cfg.acc[1];
        else if (idx == 16'd29) return cfg.acc[0];
        else                    return 1'b0;
    endfunction

endpackage

// File: rtl/bmc_slot_ctr.sv
module bmc_slot_ctr
    import bmc_pkg::*;
#(
    parameter int BLOCK_WORDS = 384,
    localparam int WIDX_W = $clog2(BLOCK_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_on,
    input  logic              step,
    output logic [HCNT_W-1:0] h_cnt,
    output logic [WIDX_W-1:0] word_idx
);

    localparam logic [HCNT_W-1:0] H_LAST = HCNT_W'(HALVES - 1);
    localparam logic [WIDX_W-1:0] W_LAST = WIDX_W'(BLOCK_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst || !line_on) begin
            h_cnt    <= '0;
            word_idx <= '0;
        end else if (step) begin
            h_cnt <= h_cnt + 1'b1;
            if (h_cnt == H_LAST) begin
                word_idx <= (word_idx == W_LAST) ? '0 : word_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bmc_word_build.sv
module bmc_word_build
    import bmc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    localparam int LSB_SLOT = 28 - SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                err,
    input  logic                user,
    input  logic                cs,
    output logic [SLOTS-1:0]    word
);

    always_comb begin
        word = '0;
        word[LSB_SLOT +: SAMPLE_W] = sample;
        word[28] = err;
        word[29] = user;
        word[30] = cs;
        word[31] = ^word[30:4];
    end

endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
    import bmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_on,
    input  logic              step,
    input  logic [HCNT_W-1:0] h_cnt,
    input  logic [SLOTS-1:0]  word_in,
    input  pre_kind_t         pre_in,
    output logic              line_out
);

    logic [SLOTS-1:0] word_q;
    logic [7:0]       pat_q;
    logic [7:0]       pat_now;
    logic             lvl_q;
    logic             line_q;

    assign pat_now  = pre_pattern(pre_in);
    assign line_out = line_q;

    always_ff @(posedge clk) begin
        if (rst || !line_on) begin
            line_q <= 1'b0;
            lvl_q  <= 1'b0;
            pat_q  <= '0;
            word_q <= '0;
        end else if (step) begin
            if (h_cnt == '0) begin
                word_q <= word_in;
                pat_q  <= pat_now;
                lvl_q  <= line_q;
                line_q <= pat_now[7] ^ line_q;
            end else if (h_cnt < HCNT_W'(PRE_HALVES)) begin
                line_q <= pat_q[3'd7 - h_cnt[2:0]] ^ lvl_q;
            end else if (!h_cnt[0]) begin
                line_q <= ~line_q;
            end else begin
                line_q <= line_q ^ word_q[h_cnt[HCNT_W-1:1]];
            end
        end
    end

endmodule

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx
    import bmc_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int BLOCK_WORDS = 384,
    localparam int WIDX_W = $clog2(BLOCK_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_on,
    input  logic                cell_en,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                err_left,
    input  logic                err_right,
    input  logic                user_bit,
    input  logic [3:0]          q_ctrl,
    input  logic [1:0]          clk_acc,
    output logic                line_out,
    output logic                sub_start,
    output logic                blk_first
);

    logic              step;
    logic              begin_sub;
    logic              is_right;
    logic [HCNT_W-1:0] h_cnt;
    logic [WIDX_W-1:0] word_idx;
    logic [SAMPLE_W-1:0] right_q;
    logic              right_err_q;
    cs_cfg_t           cfg_q;
    cs_cfg_t           cfg_live;
    cs_cfg_t           cfg_use;
    logic [SAMPLE_W-1:0] sample_sel;
    logic              err_sel;
    logic              cs_sel;
    logic [SLOTS-1:0]  word_bits;
    pre_kind_t         pre_sel;

    assign step      = line_on && cell_en;
    assign begin_sub = step && (h_cnt == '0);
    assign is_right  = word_idx[0];

    bmc_slot_ctr #(.BLOCK_WORDS(BLOCK_WORDS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .line_on  (line_on),
        .step     (step),
        .h_cnt    (h_cnt),
        .word_idx (word_idx)
    );

    // Capture registers: right sample with the pair, channel-status config with the block.
    always_ff @(posedge clk) begin
        if (rst) begin
            right_q     <= '0;
            right_err_q <= 1'b0;
            cfg_q       <= '0;
        end else if (begin_sub) begin
            if (!is_right) begin
                right_q     <= smp_right;
                right_err_q <= err_right;
            end
            if (word_idx == '0) begin
                cfg_q <= cfg_live;
            end
        end
    end

    always_comb begin
        cfg_live.ctrl = q_ctrl;
        cfg_live.acc  = clk_acc;
        cfg_use    = (word_idx == '0) ? cfg_live : cfg_q;
        sample_sel = is_right ? right_q : smp_left;
        err_sel    = is_right ? right_err_q : err_left;
        cs_sel     = cs_value(16'(word_idx >> 1), cfg_use);
        if (word_idx == '0) pre_sel = PRE_BLK;
        else if (is_right)  pre_sel = PRE_RGT;
        else                pre_sel = PRE_LEFT;
    end

    bmc_word_build #(.SAMPLE_W(SAMPLE_W)) u_build (
        .sample (sample_sel),
        .err    (err_sel),
        .user   (user_bit),
        .cs     (cs_sel),
        .word   (word_bits)
    );

    bmc_line_coder u_coder (
        .clk      (clk),
        .rst      (rst),
        .line_on  (line_on),
        .step     (step),
        .h_cnt    (h_cnt),
        .word_in  (word_bits),
        .pre_in   (pre_sel),
        .line_out (line_out)
    );

    always_ff @(posedge clk) begin
        if (rst || !line_on) begin
            sub_start <= 1'b0;
            blk_first <= 1'b0;
        end else begin
            sub_start <= begin_sub;
            blk_first <= begin_sub && (word_idx == '0);
        end
    end

endmodule

// File: rtl/bmc_subframe_tx_chk.sv
module bmc_subframe_tx_chk
    import bmc_pkg::*;
#(
    parameter int BLOCK_WORDS = 384,
    localparam int WIDX_W = $clog2(BLOCK_WORDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              line_on,
    input logic              cell_en,
    input logic              line_out,
    input logic              sub_start,
    input logic              blk_first,
    input logic [HCNT_W-1:0] h_cnt,
    input logic [WIDX_W-1:0] word_idx,
    input logic [SLOTS-1:0]  word
);

    a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
        !line_on |=> !line_out);

    a_r10_hold_line: assert property (@(posedge clk) disable iff (rst)
        (line_on && !cell_en) |=> $stable(line_out));

    a_r3_cell_edge: assert property (@(posedge clk) disable iff (rst)
        (line_on && cell_en && h_cnt >= HCNT_W'(PRE_HALVES) && !h_cnt[0])
        |=> (line_out != $past(line_out)));

    a_r8_even_parity: assert property (@(posedge clk) disable iff (rst)
        (line_on && cell_en && h_cnt == '0) |-> (^word[31:4] == 1'b0));

    a_r11_start_pulse: assert property (@(posedge clk) disable iff (rst)
        (line_on && cell_en && h_cnt == '0) |=> sub_start);

    a_r11_blk_in_sub: assert property (@(posedge clk) disable iff (rst)
        blk_first |-> sub_start);

    a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
        word_idx < WIDX_W'(BLOCK_WORDS));

endmodule

bind bmc_subframe_tx bmc_subframe_tx_chk #(.BLOCK_WORDS(BLOCK_WORDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_on   (line_on),
    .cell_en   (cell_en),
    .line_out  (line_out),
    .sub_start (sub_start),
    .blk_first (blk_first),
    .h_cnt     (h_cnt),
    .word_idx  (word_idx),
    .word      (word_bits)
);

// File: tb/sim_bmc_subframe_tx.sv
`timescale 1ns/1ps
module sim_bmc_subframe_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_on = 1'b0;
    logic        cell_en = 1'b0;
    logic [15:0] smp_left = '0;
    logic [15:0] smp_right = '0;
    logic        err_left = 1'b0;
    logic        err_right = 1'b0;
    logic        user_bit = 1'b0;
    logic [3:0]  q_ctrl = '0;
    logic [1:0]  clk_acc = '0;
    logic        line_out, sub_start, blk_first;

    always #2.5 clk = ~clk;

    bmc_subframe_tx u0 (
        .clk(clk), .rst(rst), .line_on(line_on), .cell_en(cell_en),
        .smp_left(smp_left), .smp_right(smp_right),
        .err_left(err_left), .err_right(err_right),
        .user_bit(user_bit), .q_ctrl(q_ctrl), .clk_acc(clk_acc),
        .line_out(line_out), .sub_start(sub_start), .blk_first(blk_first)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    int  cycles = 0;
    bit  timed_out = 0;
    int  seed = 1;
    bit  stepped = 0;
    int  hcount = 0;
    int  n_sub = 0;
    int  cap_n = 0;
    logic lvl = 1'b0;
    logic last_out = 1'b0;
    logic halves [64];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_left(int s, int p);
        return 16'((p * 16'h1357) ^ (s * 16'h0F0F) ^ 16'hA5C3);
    endfunction
    function automatic logic [15:0] f_right(int s, int p);
        return 16'(~((p * 16'h2461) + s));
    endfunction
    function automatic logic e_left(int s, int p);
        return ((p + s) % 7) == 3;
    endfunction
    function automatic logic e_right(int s, int p);
        return ((p + s) % 5) == 1;
    endfunction
    function automatic logic f_user(int s, int n);
        return ((n * 3 + s) % 5) < 2;
    endfunction
    function automatic logic [3:0] f_q(int s, int b);
        return 4'((b * 5 + s * 3 + 9) % 16);
    endfunction
    function automatic logic [1:0] f_acc(int s, int b);
        case ((b + s) % 3)
            0:       return 2'b10;
            1:       return 2'b00;
            default: return 2'b01;
        endcase
    endfunction

    // Expected channel-status bit from the R7 table.
    function automatic logic exp_cs(int k, logic [3:0] q, logic [1:0] a);
        if (k < 4)   return q[k];
        if (k == 8)  return 1'b1;
        if (k == 28) return a[1];
        if (k == 29) return a[0];
        return 1'b0;
    endfunction

    task automatic decode();
        int p, b;
        logic [7:0] got_pre, exp_pre;
        logic [31:0] w;
        bit edges_ok;
        logic [15:0] es;
        logic ee, ecs;
        p = n_sub / 2;
        b = n_sub / 384;
        for (int i = 0; i < 8; i++) got_pre[7-i] = halves[i];
        if (n_sub % 384 == 0)      exp_pre = 8'b1110_1000;
        else if (n_sub % 2 == 1)   exp_pre = 8'b1110_0100;
        else                       exp_pre = 8'b1110_0010;
        exp_pre = exp_pre ^ {8{lvl}};
        check(got_pre == exp_pre, "R2 R3 R12 preamble", got_pre, exp_pre);
        edges_ok = 1;
        w = '0;
        for (int i = 4; i < 32; i++) begin
            if (halves[2*i] == halves[2*i-1]) edges_ok = 0;
            w[i] = halves[2*i] ^ halves[2*i+1];
        end
        check(edges_ok, "R3 slot-start transitions", edges_ok, 1);
        es  = (n_sub % 2 == 0) ? f_left(seed, p) : f_right(seed, p);
        ee  = (n_sub % 2 == 0) ? e_left(seed, p) : e_right(seed, p);
        ecs = exp_cs(p % 192, f_q(seed, b), f_acc(seed, b));
        check(w[11:4] == 8'h00, "R4 aux and pad slots", w[11:4], 0);
        check(w[27:12] == es, "R4 sample slots", w[27:12], es);
        check(w[28] == ee, "R5 validity", w[28], ee);
        check(w[29] == f_user(seed, n_sub), "R6 user bit", w[29], f_user(seed, n_sub));
        check(w[30] == ecs, "R7 R9 channel status", w[30], ecs);
        check((^w[31:4]) == 1'b0, "R8 parity", w[31], ^w[30:4]);
        lvl = halves[63];
        n_sub++;
    endtask

    task automatic tick(input bit ce_next);
        @(negedge clk);
        cycles++;
        if (cycles > 150000) timed_out = 1;
        if (line_on && !stepped) begin
            check(line_out == last_out, "R10 hold without strobe", line_out, last_out);
        end
        if (stepped) begin
            halves[hcount] = line_out;
            hcount++;
            if (hcount == 64) begin
                hcount = 0;
                decode();
            end
        end
        if (sub_start) begin
            check(blk_first == (cap_n % 384 == 0), "R11 blk_first", blk_first, cap_n % 384 == 0);
            check(stepped && hcount == 1, "R11 sub_start timing", hcount, 1);
            if (cap_n % 2 == 0) begin
                smp_left  = f_left(seed, cap_n / 2 + 1);
                smp_right = f_right(seed, cap_n / 2 + 1);
                err_left  = e_left(seed, cap_n / 2 + 1);
                err_right = e_right(seed, cap_n / 2 + 1);
            end
            user_bit = f_user(seed, cap_n + 1);
            if (cap_n % 384 == 0) begin
                q_ctrl  = f_q(seed, cap_n / 384 + 1);
                clk_acc = f_acc(seed, cap_n / 384 + 1);
            end
            cap_n++;
        end
        last_out = line_out;
        cell_en  = ce_next;
        stepped  = line_on && ce_next;
    endtask

    task automatic prime(input int s);
        seed = s; hcount = 0; n_sub = 0; cap_n = 0; lvl = 1'b0;
        smp_left = f_left(s, 0); smp_right = f_right(s, 0);
        err_left = e_left(s, 0); err_right = e_right(s, 0);
        user_bit = f_user(s, 0);
        q_ctrl = f_q(s, 0); clk_acc = f_acc(s, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) tick(1'b0);
        rst = 1'b0;
        tick(1'b0);
        check(line_out == 1'b0, "R1 line low after reset", line_out, 0);
        check(sub_start == 1'b0 && blk_first == 1'b0, "R1 pulses low after reset", sub_start, 0);
    endtask

    task automatic t_idle();
        bit bad = 0;
        line_on = 1'b0;
        for (int i = 0; i < 100; i++) begin
            tick(1'b1);
            if (line_out || sub_start) bad = 1;
        end
        check(!bad, "R1 mode off holds line low", bad, 0);
    endtask

    task automatic t_full_block();
        prime(1);
        line_on = 1'b1;
        stepped = 1'b1; cell_en = 1'b1;
        while (n_sub < 400 && !timed_out) tick(1'b1);
    endtask

    task automatic t_stop_and_gapped();
        bit bad = 0;
        for (int i = 0; i < 30; i++) tick(1'b1);
        line_on = 1'b0;
        tick(1'b0);
        tick(1'b0);
        check(line_out == 1'b0, "R1 line low after mode off", line_out, 0);
        for (int i = 0; i < 20; i++) begin
            tick(1'b1);
            if (line_out) bad = 1;
        end
        check(!bad, "R1 line stays low while off", bad, 0);
        prime(2);
        line_on = 1'b1;
        stepped = 1'b0; cell_en = 1'b0;
        for (int i = 0; n_sub < 12 && !timed_out; i++) tick((i % 3) != 0);
        check(n_sub == 12, "R12 restart with gapped strobe", n_sub, 12);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_full_block();
        if (!timed_out) t_stop_and_gapped();
        if (timed_out) check(1'b0, "watchdog", cycles, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule